// File: doc/BRIEF.md
# Key-Protected Peripheral Write Lock

This block sits on a simple memory-mapped register bus and decides which peripheral register groups may be written. It holds one key register and two lock-control words. Each implemented bit of a lock word drives a write-inhibit line for one peripheral group. When that line is high, the group's register file rejects bus writes but still returns its contents on reads. Software opens the lock words with a two-write key handshake. The sequencer's state can be read back through the key register. Any later key write closes the lock words again.

The key register is at byte offset 0x00. The first lock word is at 0x20 and the second is at 0x40. Only the low eight bits of a key write are compared. The first key value is 0xA5 and the second is 0xF1. Both are parameters. Read data is registered: it appears on the cycle after the read strobe and is zero in any cycle that does not follow a read.

Top module: `periph_wlock`

## Requirements
- R1: After synchronous reset the sequencer is closed, both lock words are zero, every inhibit output is zero and the read data is zero.
- R2: A read of offset 0x00 returns the sequencer state in bits 7:0, with 0 = closed, 1 = half-open and 2 = open. Bits 31:8 read as zero.
- R3: In the closed state, a key write whose low byte is 0xA5 moves the sequencer to half-open, whatever the upper bits hold. Any other low byte leaves it closed.
- R4: In the half-open state, a key write whose low byte is 0xF1 moves the sequencer to open. Any other value moves it back to closed.
- R5: In the open state, every key write moves the sequencer to closed, whatever value is written.
- R6: Writes to offsets 0x20 and 0x40 change the lock words only while the sequencer is open. In the other states they leave the words and the inhibit outputs unchanged. A write to a lock word never changes the sequencer state.
- R7: The lock word at 0x20 stores bits 0–4, 6–26 and 28 (mask 0x17FFFFDF). Bits 5, 27 and 29–31 always read as zero and their inhibit lines stay zero.
- R8: The lock word at 0x40 stores only bit 0. All its other bits read as zero and their inhibit lines stay zero.
- R9: Each inhibit output equals its stored lock bit, so an accepted lock-word write shows on the inhibit outputs in the first cycle after the write edge.
- R10: Writes to any offset other than 0x00, 0x20 and 0x40 change nothing. Reads from such offsets return zero.
- R11: Read data shows the value selected in the previous cycle, as it stood before that cycle's write took effect. It is zero in every cycle not preceded by a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_addr_i | input | ADDR_W (12) | Byte offset within the block |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Registered read data |
| grp_inhibit_a_o | output | DATA_W (32) | Write-inhibit lines from the first lock word |
| grp_inhibit_b_o | output | DATA_W (32) | Write-inhibit lines from the second lock word |

## Verification
The key sequencer is driven with the correct two-write handshake and with several variants of it:
- A wrong first value, which tells a full compare from a partial one.
- A correct first value carrying nonzero upper bits, which shows that only the low byte is compared.
- A wrong second value, which must fall back to closed rather than stay half-open.
- A matching 0xA5 written while open, which must still close.

Lock words are written with all-ones and with alternating patterns in each sequencer state. This separates the write gating from the reserved-bit masking. Writes and reads at unused offsets show whether the address decode is complete. A behavioural model in the bench predicts the read data and both inhibit buses, and the bench compares them against the design on every clock.

// File: rtl/periph_wlock_pkg.sv
package periph_wlock_pkg;

  typedef enum logic [1:0] {
    SEQ_CLOSED = 2'd0,
    SEQ_HALF   = 2'd1,
    SEQ_OPEN   = 2'd2
  } seq_state_t;

  localparam int KEY_W = 8;

endpackage

// File: rtl/periph_wlock_seq.sv
module periph_wlock_seq
  import periph_wlock_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hA5,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'hF1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             key_we_i,
  input  logic [KEY_W-1:0] key_val_i,
  output seq_state_t       state_o,
  output logic             open_o
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_we_i) begin
      unique case (state_q)
        SEQ_CLOSED: state_d = (key_val_i == KEY_FIRST)  ? SEQ_HALF : SEQ_CLOSED;
        SEQ_HALF:   state_d = (key_val_i == KEY_SECOND) ? SEQ_OPEN : SEQ_CLOSED;
        default:    state_d = SEQ_CLOSED;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= SEQ_CLOSED;
    else       state_q <= state_d;
  end

  assign state_o = state_q;
  assign open_o  = (state_q == SEQ_OPEN);

  // R4: open is reachable only through the half-open state
  p_open_via_half_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == SEQ_OPEN && $past(state_q) != SEQ_OPEN) |-> $past(state_q) == SEQ_HALF);

  // R5: any key write while open closes
  p_relock_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == SEQ_OPEN && key_we_i) |=> state_q == SEQ_CLOSED);

  // R3: a wrong first key leaves the sequencer closed
  p_wrong_first_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == SEQ_CLOSED && key_we_i && key_val_i != KEY_FIRST) |=> state_q == SEQ_CLOSED);

  // R2: the state never holds an unused code
  p_legal_code_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    state_q != 2'd3);

endmodule

// File: rtl/periph_wlock_word.sv
module periph_wlock_word #(
  parameter int                 DATA_W = 32,
  parameter logic [DATA_W-1:0]  MASK   = 32'h1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              we_i,
  input  logic              open_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);

  logic accept;
  assign accept = we_i & open_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (MASK[i]) begin : g_store
      logic bit_q;
      always_ff @(posedge clk_i) begin
        if (rst_i)       bit_q <= 1'b0;
        else if (accept) bit_q <= wdata_i[i];
      end
      assign q_o[i] = bit_q;
    end else begin : g_zero
      assign q_o[i] = 1'b0;
    end
  end

  // R6: a lock word is frozen while the sequencer is not open
  p_hold_when_closed_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !open_i |=> $stable(q_o));

endmodule

// File: rtl/periph_wlock.sv
module periph_wlock
  import periph_wlock_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                DATA_W     = 32,
  parameter int                KEY_OFS    = 'h00,
  parameter int                LOCKA_OFS  = 'h20,
  parameter int                LOCKB_OFS  = 'h40,
  parameter logic [DATA_W-1:0] MASK_A     = 32'h17FF_FFDF,
  parameter logic [DATA_W-1:0] MASK_B     = 32'h0000_0001,
  parameter logic [KEY_W-1:0]  KEY_FIRST  = 8'hA5,
  parameter logic [KEY_W-1:0]  KEY_SECOND = 8'hF1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [DATA_W-1:0] grp_inhibit_a_o,
  output logic [DATA_W-1:0] grp_inhibit_b_o
);

  localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(KEY_OFS);
  localparam logic [ADDR_W-1:0] A_LOCKA = ADDR_W'(LOCKA_OFS);
  localparam logic [ADDR_W-1:0] A_LOCKB = ADDR_W'(LOCKB_OFS);

  logic hit_key, hit_a, hit_b;
  assign hit_key = (bus_addr_i == A_KEY);
  assign hit_a   = (bus_addr_i == A_LOCKA);
  assign hit_b   = (bus_addr_i == A_LOCKB);

  seq_state_t        state;
  logic              open;
  logic [DATA_W-1:0] word_a, word_b;

  periph_wlock_seq #(
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .key_we_i (bus_wr_i & hit_key),
    .key_val_i(bus_wdata_i[KEY_W-1:0]),
    .state_o  (state),
    .open_o   (open)
  );

  periph_wlock_word #(.DATA_W(DATA_W), .MASK(MASK_A)) u_word_a (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .we_i   (bus_wr_i & hit_a),
    .open_i (open),
    .wdata_i(bus_wdata_i),
    .q_o    (word_a)
  );

  periph_wlock_word #(.DATA_W(DATA_W), .MASK(MASK_B)) u_word_b (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .we_i   (bus_wr_i & hit_b),
    .open_i (open),
    .wdata_i(bus_wdata_i),
    .q_o    (word_b)
  );

  logic [DATA_W-1:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    if (hit_key)    rd_sel = DATA_W'(state);
    else if (hit_a) rd_sel = word_a;
    else if (hit_b) rd_sel = word_b;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)         bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_sel;
    else               bus_rdata_o <= '0;
  end

  assign grp_inhibit_a_o = word_a;
  assign grp_inhibit_b_o = word_b;

  // R11: no read strobe in the previous cycle means zero read data
  p_rdata_idle_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(bus_rd_i) |-> bus_rdata_o == '0);

  // R10: a write to an unused offset leaves both inhibit buses unchanged
  p_unused_write_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_wr_i && !hit_key && !hit_a && !hit_b)
      |=> ($stable(grp_inhibit_a_o) && $stable(grp_inhibit_b_o)));

  // R7: reserved inhibit lines of the first word never rise
  p_reserved_a_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (grp_inhibit_a_o & ~MASK_A) == '0);

endmodule

// File: tb/periph_wlock_tb.sv
module periph_wlock_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr, rd;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata, inh_a, inh_b;

  always #4 clk = ~clk;

  periph_wlock u_dut (
    .clk_i          (clk),
    .rst_i          (rst),
    .bus_wr_i       (wr),
    .bus_rd_i       (rd),
    .bus_addr_i     (addr),
    .bus_wdata_i    (wdata),
    .bus_rdata_o    (rdata),
    .grp_inhibit_a_o(inh_a),
    .grp_inhibit_b_o(inh_b)
  );

  localparam logic [31:0] MA = 32'h17FF_FFDF;
  localparam logic [31:0] MB = 32'h0000_0001;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  // behavioural reference model
  int          m_state;
  logic [31:0] m_a, m_b, m_rd;

  function automatic logic [31:0] model_read(logic [11:0] a);
    if (a == 12'h000) return 32'(m_state);
    if (a == 12'h020) return m_a;
    if (a == 12'h040) return m_b;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_a = 0; m_b = 0; m_rd = 0;
    end else begin
      m_rd = rd ? model_read(addr) : 32'h0;
      if (wr) begin
        if (addr == 12'h000) begin
          if (m_state == 0)      m_state = (wdata[7:0] == 8'hA5) ? 1 : 0;
          else if (m_state == 1) m_state = (wdata[7:0] == 8'hF1) ? 2 : 0;
          else                   m_state = 0;
        end else if (addr == 12'h020 && m_state == 2) m_a = wdata & MA;
        else if (addr == 12'h040 && m_state == 2)     m_b = wdata & MB;
      end
    end
    started = 1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !rst) begin
      check("R11 rdata", rdata, m_rd);
      check("R9 inhibit_a", inh_a, m_a);
      check("R9 inhibit_b", inh_b, m_b);
    end
  end

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = 32'h0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    check("R1 rdata", rdata, 32'h0);
    check("R1 inhibit_a", inh_a, 32'h0);
    check("R1 inhibit_b", inh_b, 32'h0);
    bus_read(12'h000, v); check("R1 key state", v, 32'h0);

    // R6: lock word writes ignored while closed
    bus_write(12'h020, 32'hFFFF_FFFF);
    bus_read(12'h020, v); check("R6 closed word_a", v, 32'h0);
    check("R6 closed inhibit", inh_a, 32'h0);

    // R3: wrong first key stays closed
    bus_write(12'h000, 32'h0000_00A4);
    bus_read(12'h000, v); check("R3 wrong first", v, 32'h0);
    // R3: upper bits ignored
    bus_write(12'h000, 32'h1234_56A5);
    bus_read(12'h000, v); check("R3 half via low byte", v, 32'h1);
    // R6: ignored while half-open, state unchanged
    bus_write(12'h040, 32'hFFFF_FFFF);
    bus_read(12'h040, v); check("R6 half word_b", v, 32'h0);
    bus_read(12'h000, v); check("R6 state kept half", v, 32'h1);
    // R4: wrong second key falls back
    bus_write(12'h000, 32'h0000_00A5);
    bus_read(12'h000, v); check("R4 wrong second", v, 32'h0);
    // R4: correct sequence opens
    bus_write(12'h000, 32'h0000_00A5);
    bus_write(12'h000, 32'h0000_00F1);
    bus_read(12'h000, v); check("R2 R4 open code", v, 32'h2);

    // R7 R8 R9: masked stores, inhibit visible right after the write
    bus_write(12'h020, 32'hFFFF_FFFF);
    check("R9 inhibit_a after write", inh_a, MA);
    bus_read(12'h020, v); check("R7 word_a mask", v, MA);
    bus_write(12'h040, 32'hFFFF_FFFF);
    check("R8 inhibit_b", inh_b, 32'h1);
    bus_read(12'h040, v); check("R8 word_b mask", v, 32'h1);
    bus_write(12'h020, 32'hAAAA_5555);
    bus_read(12'h020, v); check("R7 pattern", v, 32'hAAAA_5555 & MA);

    // R10: unused offsets
    bus_write(12'h004, 32'hFFFF_FFFF);
    bus_write(12'h060, 32'h0);
    bus_read(12'h004, v); check("R10 unused read", v, 32'h0);
    bus_read(12'h020, v); check("R10 word_a kept", v, 32'hAAAA_5555 & MA);
    bus_read(12'h000, v); check("R10 state kept", v, 32'h2);

    // R5: any key write while open closes, even the first key
    bus_write(12'h000, 32'h0000_00A5);
    bus_read(12'h000, v); check("R5 relock", v, 32'h0);
    bus_write(12'h020, 32'h0);
    check("R6 after relock", inh_a, 32'hAAAA_5555 & MA);

    // R11: read during write returns the pre-write value
    bus_write(12'h000, 32'h0000_00A5);
    @(negedge clk);
    wr = 1'b1; rd = 1'b1; addr = 12'h000; wdata = 32'hF1;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    check("R11 pre-write value", rdata, 32'h1);
    bus_write(12'h020, 32'h0);
    bus_write(12'h040, 32'h0);
    check("R9 cleared a", inh_a, 32'h0);
    check("R9 cleared b", inh_b, 32'h0);

    repeat (3) @(negedge clk);
    done = 1;
    summary();
  end

endmodule